// File: doc/BRIEF.md
# PHY Clock-Path Configuration Sequencer

This block reprograms the clock path of a storage-card interface PHY each time the host moves to a new bus clock or timing mode. A single request strobe captures the target clock (in Hz), the timing-mode index, a table of output-tap values indexed by mode, the input-tap value, the charge-pump trim, the line impedance in ohms, the strobe and buffer selections, a legacy-table flag and two variant flags. The sequencer then runs a fixed list of masked register writes and status reads on a 32-bit register port. That port has one ready handshake per access and is attached to the PHY register file.

Two clock paths exist. When the mode is fast and the clock is high enough, the block uses the locked delay loop: it sets the loop's frequency range, trim and drive, enables the loop and polls its ready flag. A cycle-count timeout bounds the poll. Otherwise it uses the fixed delay chain: it disables the loop, routes both directions through the chain, and loads the input tap inside an open change window. Both paths end with the clock-buffer selection. The block then pulses `done`, and raises `lock_err` with it if the loop never reported ready.

Register map, as addressed by `reg_addr`. Address 0 is loop control: enable at bit 0, trim at [7:4], drive code at [10:8]. Address 1 is taps: output-tap select at [3:0], output-tap enable at bit 4, input tap at [12:8], change window at bit 13, strobe at [31:24]. Address 2 is clock select: buffer at [2:0]; a 3-bit frequency field at [6:4], or range bits at 4 (low range) and 5 (mid range); transmit chain at bit 8 and receive chain at bit 9. Address 3 is status, with loop ready at bit 0. Every write carries a mask and only touches the masked bits.

Top module: `phy_clk_seq`

## Requirements
- R1: While reset is held and afterwards until a request, `reg_wr`, `reg_rd`, `busy` and `done` stay low.
- R2: The first access of every sequence is a write to address 0 with mask 0x1 and data 0, which clears the loop enable.
- R3: The second access writes address 1. It sets output-tap select [3:0] and output-tap enable bit 4. The enable is 1 only for mode indices above 4. The tap value is table entry 0 when `legacy` is set and table entry `mode` otherwise.
- R4: In mode 10 that same write also carries `strobe` at bit 24 upward. Only the low 4 bits are written (mask [27:24]) when `strb4` is set; all 8 bits are written (mask [31:24]) when it is clear.
- R5: The loop path is taken exactly when the mode index is above 4 and `clk_hz` is at least 50,000,000. Any other request takes the delay-chain path.
- R6: On the loop path the third access clears address 2 bits 9:8. The fourth sets the frequency. When `freq2` is set, bits 5:4 are written as 00 for 200 MHz, as bit 5 set for 100 MHz, and as bit 4 set for any other clock. When `freq2` is clear, field [6:4] is written as 0 for 200 MHz and as 4 for any other clock.
- R7: The loop path next writes trim to [7:4] and the drive code to [10:8] at address 0, in one access. The drive code is 0 for 50 Ω, 1 for 33 Ω, 2 for 66 Ω, 3 for 100 Ω, 4 for 40 Ω, and 0 for any other value. The following access sets bit 0 of address 0.
- R8: The block then reads address 3 until bit 0 is 1. If the bit is still 0 after `TMO_CYC` cycles of polling, the block ends the sequence, asserts `lock_err` together with `done`, and skips the buffer write.
- R9: The delay-chain path writes, in this order: address 0 bit 0 cleared; address 2 bits 9:8 set; address 1 bit 13 set; address 1 [12:8] set to `itap`; address 1 bit 13 cleared.
- R10: A completed sequence ends with a write of `bufsel` to address 2 [2:0]. One cycle later `done` pulses for one cycle and `busy` is low.
- R11: A request is accepted only while `busy` is low. A request raised during a sequence, or a change of the inputs after acceptance, leaves the access list of that sequence unchanged and does not start another one.
- R12: Each access holds its address, data and mask steady until `reg_ack`. Read and write are never requested together, and write data is zero outside the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start strobe, accepted when idle |
| clk_hz | input | FREQ_W | Target bus clock in Hz |
| mode | input | MODE_W | Timing-mode index |
| otap_tbl | input | N_MODES*4 | Output-tap value per mode, entry i at [4i+3:4i] |
| itap | input | 5 | Input-tap value for the delay-chain path |
| trim | input | 4 | Charge-pump trim |
| drv_ohm | input | 7 | Line impedance in ohms |
| strobe | input | 8 | Strobe selection for mode 10 |
| bufsel | input | 3 | Clock-buffer selection |
| legacy | input | 1 | Use table entry 0 for every mode |
| freq2 | input | 1 | Two-bit frequency-range variant |
| strb4 | input | 1 | Narrow strobe-field variant |
| reg_wr | output | 1 | Masked write request |
| reg_rd | output | 1 | Read request |
| reg_addr | output | 2 | Register address |
| reg_wdata | output | 32 | Write data |
| reg_wmask | output | 32 | Write bit mask |
| reg_ack | input | 1 | Access complete |
| reg_rdata | input | 32 | Read data, valid with `reg_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| lock_err | output | 1 | Loop lock timed out, valid with `done` |

## Verification
The hardest case to reach is the lock timeout. Reaching it needs a PHY that accepts the loop enable and then never reports ready. The bench's register model therefore keeps the ready bit low on command, and one sequence runs into the poll limit to prove that no buffer write follows. A second hard case is a new request arriving mid-sequence with different inputs. The bench raises it several accesses in and checks that the access list does not change. The 49,999,999 Hz and 50,000,000 Hz clocks are also driven, to pin down the path boundary. A model with slow acknowledges stretches every access.

// File: rtl/phy_seq_pkg.sv
`timescale 1ns/1ps
package phy_seq_pkg;
   localparam int REG_W  = 32;
   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_CTL  = 2'd0;
   localparam logic [ADDR_W-1:0] A_TAP  = 2'd1;
   localparam logic [ADDR_W-1:0] A_CLK  = 2'd2;
   localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

   localparam int CTL_EN       = 0;
   localparam int CTL_TRIM_LSB = 4;
   localparam int TRIM_W       = 4;
   localparam int CTL_DRV_LSB  = 8;
   localparam int DRV_W        = 3;

   localparam int TAP_OSEL_LSB = 0;
   localparam int OTAP_W       = 4;
   localparam int TAP_OEN      = 4;
   localparam int TAP_ISEL_LSB = 8;
   localparam int ITAP_W       = 5;
   localparam int TAP_WIN      = 13;
   localparam int TAP_STRB_LSB = 24;
   localparam int STRB_W       = 8;
   localparam int STRB_NARROW  = 4;

   localparam int CLK_BUF_LSB  = 0;
   localparam int BUF_W        = 3;
   localparam int CLK_FREQ_LSB = 4;
   localparam int FREQ3_W      = 3;
   localparam int CLK_LOWRNG   = 4;
   localparam int CLK_MIDRNG   = 5;
   localparam int CLK_TXCHAIN  = 8;
   localparam int CLK_RXCHAIN  = 9;

   localparam int STAT_RDY     = 0;
   localparam int OHM_W        = 7;

   typedef enum logic [3:0] {
      ST_IDLE, ST_LOOP_OFF, ST_OTAP, ST_CHAIN_CLR, ST_FREQ, ST_TRIM,
      ST_LOOP_ON, ST_POLL, ST_CH_LOOP_OFF, ST_CHAIN_SET, ST_WIN_OPEN,
      ST_ITAP, ST_WIN_SHUT, ST_BUF
   } step_e;

   function automatic logic [DRV_W-1:0] drv_code(input logic [OHM_W-1:0] ohm);
      case (ohm)
         7'd33:   drv_code = 3'd1;
         7'd66:   drv_code = 3'd2;
         7'd100:  drv_code = 3'd3;
         7'd40:   drv_code = 3'd4;
         default: drv_code = 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/phy_seq_enc.sv
`timescale 1ns/1ps
module phy_seq_enc
   import phy_seq_pkg::*;
#(
   parameter int N_MODES   = 11,
   parameter int MODE_W    = 4,
   parameter int FREQ_W    = 32,
   parameter int IDX_SDR25 = 4,
   parameter int IDX_HS400 = 10,
   parameter int SLOW_HZ   = 50_000_000,
   parameter int HZ_TOP    = 200_000_000,
   parameter int HZ_MID    = 100_000_000
) (
   input  logic [MODE_W-1:0]         mode,
   input  logic [FREQ_W-1:0]         hz,
   input  logic [N_MODES*OTAP_W-1:0] otap_tbl,
   input  logic                      legacy,
   input  logic                      freq2,
   input  logic                      strb4,
   input  logic [STRB_W-1:0]         strobe,
   input  logic [TRIM_W-1:0]         trim,
   input  logic [OHM_W-1:0]          drv_ohm,
   output logic                      loop_path,
   output logic [REG_W-1:0]          tap_mask,
   output logic [REG_W-1:0]          tap_data,
   output logic [REG_W-1:0]          frq_mask,
   output logic [REG_W-1:0]          frq_data,
   output logic [REG_W-1:0]          trm_mask,
   output logic [REG_W-1:0]          trm_data
);
   logic [OTAP_W-1:0] otap_arr [N_MODES];
   logic [OTAP_W-1:0] osel;
   logic              fast_mode, hs400, at_top, at_mid;

   for (genvar g = 0; g < N_MODES; g++) begin : g_unpack
      assign otap_arr[g] = otap_tbl[g*OTAP_W +: OTAP_W];
   end

   assign fast_mode = mode > MODE_W'(IDX_SDR25);
   assign hs400     = mode == MODE_W'(IDX_HS400);
   assign at_top    = hz == FREQ_W'(HZ_TOP);
   assign at_mid    = hz == FREQ_W'(HZ_MID);
   assign loop_path = fast_mode && (hz >= FREQ_W'(SLOW_HZ));

   always_comb begin
      osel = otap_arr[0];
      if (!legacy)
         for (int i = 1; i < N_MODES; i++)
            if (mode == MODE_W'(i)) osel = otap_arr[i];
   end

   always_comb begin
      tap_mask = '0;
      tap_data = '0;
      tap_mask[TAP_OSEL_LSB +: OTAP_W] = '1;
      tap_mask[TAP_OEN]                = 1'b1;
      tap_data[TAP_OSEL_LSB +: OTAP_W] = osel;
      tap_data[TAP_OEN]                = fast_mode;
      if (hs400) begin
         if (strb4) begin
            tap_mask[TAP_STRB_LSB +: STRB_NARROW] = '1;
            tap_data[TAP_STRB_LSB +: STRB_NARROW] = strobe[STRB_NARROW-1:0];
         end else begin
            tap_mask[TAP_STRB_LSB +: STRB_W] = '1;
            tap_data[TAP_STRB_LSB +: STRB_W] = strobe;
         end
      end
   end

   always_comb begin
      frq_mask = '0;
      frq_data = '0;
      if (freq2) begin
         frq_mask[CLK_LOWRNG] = 1'b1;
         frq_mask[CLK_MIDRNG] = 1'b1;
         if (!at_top) begin
            if (at_mid) frq_data[CLK_MIDRNG] = 1'b1;
            else        frq_data[CLK_LOWRNG] = 1'b1;
         end
      end else begin
         frq_mask[CLK_FREQ_LSB +: FREQ3_W] = '1;
         if (!at_top) frq_data[CLK_FREQ_LSB +: FREQ3_W] = 3'd4;
      end
   end

   always_comb begin
      trm_mask = '0;
      trm_data = '0;
      trm_mask[CTL_TRIM_LSB +: TRIM_W] = '1;
      trm_mask[CTL_DRV_LSB +: DRV_W]   = '1;
      trm_data[CTL_TRIM_LSB +: TRIM_W] = trim;
      trm_data[CTL_DRV_LSB +: DRV_W]   = drv_code(drv_ohm);
   end
endmodule

// File: rtl/phy_seq_tmo.sv
`timescale 1ns/1ps
module phy_seq_tmo #(
   parameter int TMO_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CNT_W = $clog2(TMO_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("TMO_CYC must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign expired = cnt == LAST;
endmodule

// File: rtl/phy_clk_seq.sv
`timescale 1ns/1ps
module phy_clk_seq
   import phy_seq_pkg::*;
#(
   parameter int N_MODES   = 11,
   parameter int MODE_W    = 4,
   parameter int FREQ_W    = 32,
   parameter int IDX_SDR25 = 4,
   parameter int IDX_HS400 = 10,
   parameter int SLOW_HZ   = 50_000_000,
   parameter int HZ_TOP    = 200_000_000,
   parameter int HZ_MID    = 100_000_000,
   parameter int TMO_CYC   = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req,
   input  logic [FREQ_W-1:0]         clk_hz,
   input  logic [MODE_W-1:0]         mode,
   input  logic [N_MODES*4-1:0]      otap_tbl,
   input  logic [4:0]                itap,
   input  logic [3:0]                trim,
   input  logic [6:0]                drv_ohm,
   input  logic [7:0]                strobe,
   input  logic [2:0]                bufsel,
   input  logic                      legacy,
   input  logic                      freq2,
   input  logic                      strb4,
   output logic                      reg_wr,
   output logic                      reg_rd,
   output logic [1:0]                reg_addr,
   output logic [31:0]               reg_wdata,
   output logic [31:0]               reg_wmask,
   input  logic                      reg_ack,
   input  logic [31:0]               reg_rdata,
   output logic                      busy,
   output logic                      done,
   output logic                      lock_err
);
   if (N_MODES > (1 << MODE_W)) begin : g_bad_modes
      $error("N_MODES does not fit in MODE_W");
   end
   if (IDX_HS400 >= N_MODES || IDX_SDR25 >= IDX_HS400) begin : g_bad_idx
      $error("mode index parameters out of order");
   end

   step_e                 step, step_nx;
   logic                  fin, fail, expired, loop_path, rdy;
   logic                  done_q, err_q;
   logic [MODE_W-1:0]     mode_q;
   logic [FREQ_W-1:0]     hz_q;
   logic [N_MODES*4-1:0]  tbl_q;
   logic [ITAP_W-1:0]     itap_q;
   logic [TRIM_W-1:0]     trim_q;
   logic [OHM_W-1:0]      ohm_q;
   logic [STRB_W-1:0]     strobe_q;
   logic [BUF_W-1:0]      buf_q;
   logic                  legacy_q, freq2_q, strb4_q;
   logic [REG_W-1:0]      tap_mask, tap_data, frq_mask, frq_data, trm_mask, trm_data;
   logic                  op_rd;
   logic [ADDR_W-1:0]     op_addr;
   logic [REG_W-1:0]      op_mask, op_data;
   logic                  unused_rdata;

   assign rdy          = reg_rdata[STAT_RDY];
   assign unused_rdata = ^reg_rdata;

   phy_seq_enc #(
      .N_MODES(N_MODES), .MODE_W(MODE_W), .FREQ_W(FREQ_W), .IDX_SDR25(IDX_SDR25),
      .IDX_HS400(IDX_HS400), .SLOW_HZ(SLOW_HZ), .HZ_TOP(HZ_TOP), .HZ_MID(HZ_MID)
   ) u_enc (
      .mode(mode_q), .hz(hz_q), .otap_tbl(tbl_q), .legacy(legacy_q), .freq2(freq2_q),
      .strb4(strb4_q), .strobe(strobe_q), .trim(trim_q), .drv_ohm(ohm_q),
      .loop_path(loop_path), .tap_mask(tap_mask), .tap_data(tap_data),
      .frq_mask(frq_mask), .frq_data(frq_data), .trm_mask(trm_mask), .trm_data(trm_data)
   );

   phy_seq_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
      .clk(clk), .rst_n(rst_n), .run(step == ST_POLL), .expired(expired)
   );

   // one register access per step
   always_comb begin
      op_rd   = 1'b0;
      op_addr = A_CTL;
      op_mask = '0;
      op_data = '0;
      case (step)
         ST_LOOP_OFF, ST_CH_LOOP_OFF: op_mask[CTL_EN] = 1'b1;
         ST_OTAP: begin op_addr = A_TAP; op_mask = tap_mask; op_data = tap_data; end
         ST_CHAIN_CLR: begin
            op_addr = A_CLK;
            op_mask[CLK_TXCHAIN] = 1'b1;
            op_mask[CLK_RXCHAIN] = 1'b1;
         end
         ST_FREQ: begin op_addr = A_CLK; op_mask = frq_mask; op_data = frq_data; end
         ST_TRIM: begin op_mask = trm_mask; op_data = trm_data; end
         ST_LOOP_ON: begin op_mask[CTL_EN] = 1'b1; op_data[CTL_EN] = 1'b1; end
         ST_POLL: begin op_rd = 1'b1; op_addr = A_STAT; end
         ST_CHAIN_SET: begin
            op_addr = A_CLK;
            op_mask[CLK_TXCHAIN] = 1'b1; op_mask[CLK_RXCHAIN] = 1'b1;
            op_data[CLK_TXCHAIN] = 1'b1; op_data[CLK_RXCHAIN] = 1'b1;
         end
         ST_WIN_OPEN: begin
            op_addr = A_TAP; op_mask[TAP_WIN] = 1'b1; op_data[TAP_WIN] = 1'b1;
         end
         ST_ITAP: begin
            op_addr = A_TAP;
            op_mask[TAP_ISEL_LSB +: ITAP_W] = '1;
            op_data[TAP_ISEL_LSB +: ITAP_W] = itap_q;
         end
         ST_WIN_SHUT: begin op_addr = A_TAP; op_mask[TAP_WIN] = 1'b1; end
         ST_BUF: begin
            op_addr = A_CLK;
            op_mask[CLK_BUF_LSB +: BUF_W] = '1;
            op_data[CLK_BUF_LSB +: BUF_W] = buf_q;
         end
         default: ;
      endcase
   end

   // successor once the current access is acknowledged
   always_comb begin
      step_nx = step;
      fin     = 1'b0;
      fail    = 1'b0;
      case (step)
         ST_LOOP_OFF:    step_nx = ST_OTAP;
         ST_OTAP:        step_nx = loop_path ? ST_CHAIN_CLR : ST_CH_LOOP_OFF;
         ST_CHAIN_CLR:   step_nx = ST_FREQ;
         ST_FREQ:        step_nx = ST_TRIM;
         ST_TRIM:        step_nx = ST_LOOP_ON;
         ST_LOOP_ON:     step_nx = ST_POLL;
         ST_POLL: begin
            if (rdy) step_nx = ST_BUF;
            else if (expired) begin step_nx = ST_IDLE; fin = 1'b1; fail = 1'b1; end
         end
         ST_CH_LOOP_OFF: step_nx = ST_CHAIN_SET;
         ST_CHAIN_SET:   step_nx = ST_WIN_OPEN;
         ST_WIN_OPEN:    step_nx = ST_ITAP;
         ST_ITAP:        step_nx = ST_WIN_SHUT;
         ST_WIN_SHUT:    step_nx = ST_BUF;
         ST_BUF: begin step_nx = ST_IDLE; fin = 1'b1; end
         default:        step_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step     <= ST_IDLE;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         mode_q   <= '0;
         hz_q     <= '0;
         tbl_q    <= '0;
         itap_q   <= '0;
         trim_q   <= '0;
         ohm_q    <= '0;
         strobe_q <= '0;
         buf_q    <= '0;
         legacy_q <= 1'b0;
         freq2_q  <= 1'b0;
         strb4_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (step == ST_IDLE) begin
            if (req) begin
               step     <= ST_LOOP_OFF;
               mode_q   <= mode;
               hz_q     <= clk_hz;
               tbl_q    <= otap_tbl;
               itap_q   <= itap;
               trim_q   <= trim;
               ohm_q    <= drv_ohm;
               strobe_q <= strobe;
               buf_q    <= bufsel;
               legacy_q <= legacy;
               freq2_q  <= freq2;
               strb4_q  <= strb4;
            end
         end else if (reg_ack) begin
            step   <= step_nx;
            done_q <= fin;
            err_q  <= fail;
         end
      end
   end

   assign busy      = step != ST_IDLE;
   assign reg_wr    = busy && !op_rd;
   assign reg_rd    = busy && op_rd;
   assign reg_addr  = op_addr;
   assign reg_wmask = op_mask;
   assign reg_wdata = op_data & op_mask;
   assign done      = done_q;
   assign lock_err  = err_q;
endmodule

// File: rtl/phy_clk_seq_chk.sv
`timescale 1ns/1ps
module phy_clk_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        done,
   input logic        lock_err,
   input logic        reg_wr,
   input logic        reg_rd,
   input logic        reg_ack,
   input logic [1:0]  reg_addr,
   input logic [31:0] reg_wdata,
   input logic [31:0] reg_wmask
);
   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!reg_wr && !reg_rd));

   p_first_clears_loop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (reg_wr && reg_addr == 2'd0 && reg_wmask == 32'h1 && reg_wdata == 32'h0));

   p_err_only_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_err |-> done);

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_no_rd_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));

   p_hold_until_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_wr || reg_rd) && !reg_ack) |=>
         ((reg_wr || reg_rd) && $stable(reg_addr) && $stable(reg_wdata) && $stable(reg_wmask)));

   p_data_inside_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> ((reg_wdata & ~reg_wmask) == 32'h0));
endmodule

bind phy_clk_seq phy_clk_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .lock_err(lock_err),
   .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_ack(reg_ack), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_wmask(reg_wmask)
);

// File: tb/tb_phy_clk_seq.sv
`timescale 1ns/1ps
module tb_phy_clk_seq;
   localparam int N_MODES = 11;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 req = 1'b0;
   logic [31:0]          clk_hz = '0;
   logic [3:0]           mode = '0;
   logic [N_MODES*4-1:0] otap_tbl = '0;
   logic [4:0]           itap = 5'h13;
   logic [3:0]           trim = 4'hA;
   logic [6:0]           drv_ohm = 7'd50;
   logic [7:0]           strobe = 8'hC5;
   logic [2:0]           bufsel = 3'h5;
   logic                 legacy = 1'b0, freq2 = 1'b1, strb4 = 1'b1;
   logic                 reg_wr, reg_rd, reg_ack, busy, done, lock_err;
   logic [1:0]           reg_addr;
   logic [31:0]          reg_wdata, reg_wmask, reg_rdata;

   always #2.5 clk = ~clk;

   phy_clk_seq dut (
      .clk(clk), .rst_n(rst_n), .req(req), .clk_hz(clk_hz), .mode(mode),
      .otap_tbl(otap_tbl), .itap(itap), .trim(trim), .drv_ohm(drv_ohm),
      .strobe(strobe), .bufsel(bufsel), .legacy(legacy), .freq2(freq2), .strb4(strb4),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wmask(reg_wmask), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
      .busy(busy), .done(done), .lock_err(lock_err)
   );

   // PHY register model
   logic [31:0] m_regs [4];
   logic        ack, rdy;
   int          lat_cnt, lk_cnt;
   int          slow_lat = 0;
   bit          allow_lock = 1'b1;

   assign reg_ack   = ack;
   assign reg_rdata = {31'b0, rdy};

   always @(posedge clk) begin
      if (!rst_n) begin
         ack <= 1'b0; rdy <= 1'b0; lat_cnt <= 0; lk_cnt <= 0;
         for (int i = 0; i < 4; i++) m_regs[i] <= '0;
      end else begin
         if (ack) ack <= 1'b0;
         else if (reg_wr || reg_rd) begin
            if (lat_cnt >= slow_lat) begin ack <= 1'b1; lat_cnt <= 0; end
            else lat_cnt <= lat_cnt + 1;
         end
         if (reg_wr && ack)
            m_regs[reg_addr] <= (m_regs[reg_addr] & ~reg_wmask) | (reg_wdata & reg_wmask);
         if (m_regs[0][0] && allow_lock) begin
            if (lk_cnt < 5) lk_cnt <= lk_cnt + 1;
            else rdy <= 1'b1;
         end else begin
            lk_cnt <= 0; rdy <= 1'b0;
         end
      end
   end

   // scoreboard
   typedef struct {
      logic [1:0]  a;
      logic [31:0] m;
      logic [31:0] d;
      string       tag;
   } exp_t;
   exp_t exp_q[$];
   int   n_chk = 0, n_fail = 0;
   exp_t cur;

   task automatic push(input logic [1:0] a, input logic [31:0] m, input logic [31:0] d,
                       input string tag);
      exp_t e;
      e.a = a; e.m = m; e.d = d; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && reg_wr && reg_ack) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R11 unexpected write: actual a=%0d m=%h d=%h expected none",
                     reg_addr, reg_wmask, reg_wdata);
         end else begin
            cur = exp_q.pop_front();
            if (reg_addr !== cur.a || reg_wmask !== cur.m || reg_wdata !== cur.d) begin
               n_fail++;
               $display("FAIL %s write: actual a=%0d m=%h d=%h expected a=%0d m=%h d=%h",
                        cur.tag, reg_addr, reg_wmask, reg_wdata, cur.a, cur.m, cur.d);
            end
         end
      end
   end

   function automatic logic [2:0] ohm_code(input logic [6:0] ohm);
      if (ohm == 7'd33) return 3'd1;
      if (ohm == 7'd66) return 3'd2;
      if (ohm == 7'd100) return 3'd3;
      if (ohm == 7'd40) return 3'd4;
      return 3'd0;
   endfunction

   task automatic run_case(input logic [3:0] m, input logic [31:0] hz, input bit lg,
                           input bit f2, input bit s4, input logic [6:0] ohm,
                           input bit lock_ok, input bit poke);
      logic [3:0]  osel;
      logic [31:0] tm, td, fm, fd;
      bit          oen, dll, saw;
      mode = m; clk_hz = hz; legacy = lg; freq2 = f2; strb4 = s4; drv_ohm = ohm;
      allow_lock = lock_ok;
      osel = lg ? otap_tbl[3:0] : otap_tbl[m*4 +: 4];
      oen  = m > 4;
      dll  = (m > 4) && (hz >= 32'd50_000_000);
      tm = 32'h1F; td = {27'b0, oen, osel};
      if (m == 4'd10) begin
         if (s4) begin tm |= 32'h0F00_0000; td |= {4'h0, strobe[3:0], 24'h0}; end
         else    begin tm |= 32'hFF00_0000; td |= {strobe, 24'h0}; end
      end
      push(2'd0, 32'h1, 32'h0, "R2");
      push(2'd1, tm, td, (m == 4'd10) ? "R4" : "R3");
      if (dll) begin
         push(2'd2, 32'h300, 32'h0, "R5");
         if (f2) begin
            fm = 32'h30;
            fd = (hz == 32'd200_000_000) ? 32'h0 : (hz == 32'd100_000_000) ? 32'h20 : 32'h10;
         end else begin
            fm = 32'h70;
            fd = (hz == 32'd200_000_000) ? 32'h0 : 32'h40;
         end
         push(2'd2, fm, fd, "R6");
         push(2'd0, 32'h7F0, {21'b0, ohm_code(ohm), trim, 4'h0}, "R7");
         push(2'd0, 32'h1, 32'h1, "R7");
         if (lock_ok) push(2'd2, 32'h7, {29'b0, bufsel}, "R10");
      end else begin
         push(2'd0, 32'h1, 32'h0, "R5");
         push(2'd2, 32'h300, 32'h300, "R9");
         push(2'd1, 32'h2000, 32'h2000, "R9");
         push(2'd1, 32'h1F00, {19'b0, itap, 8'h0}, "R9");
         push(2'd1, 32'h2000, 32'h0, "R9");
         push(2'd2, 32'h7, {29'b0, bufsel}, "R10");
      end
      @(negedge clk) req = 1'b1;
      @(negedge clk) req = 1'b0;
      if (poke) begin
         repeat (5) @(negedge clk);
         chk(busy == 1'b1, "R11", "busy mid-sequence", longint'(busy), 1);
         mode = 4'd0; clk_hz = 32'd0; legacy = 1'b1;
         req = 1'b1;
         @(negedge clk) req = 1'b0;
      end
      saw = 1'b0;
      for (int i = 0; i < 3000 && !saw; i++) begin
         @(negedge clk);
         if (done) saw = 1'b1;
      end
      chk(saw, "R10", "done pulse seen", longint'(saw), 1);
      chk(lock_err == (dll && !lock_ok), "R8", "lock_err with done",
          longint'(lock_err), longint'(dll && !lock_ok));
      chk(exp_q.size() == 0, "R10", "writes still expected", exp_q.size(), 0);
      repeat (8) @(negedge clk);
      chk(!busy, "R11", "idle after sequence", longint'(busy), 0);
      exp_q.delete();
   endtask

   initial begin
      for (int i = 0; i < N_MODES; i++) otap_tbl[i*4 +: 4] = 4'(i * 3 + 2);
      repeat (4) @(negedge clk);
      chk(!reg_wr && !reg_rd, "R1", "no access in reset", longint'(reg_wr | reg_rd), 0);
      chk(!busy && !done, "R1", "busy/done in reset", longint'(busy | done), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy && !reg_wr, "R1", "idle after reset", longint'(busy | reg_wr), 0);

      run_case(4'd9, 32'd200_000_000, 0, 1, 1, 7'd50, 1, 0);   // R6 range 00
      run_case(4'd5, 32'd100_000_000, 0, 1, 1, 7'd33, 1, 0);   // R6 mid range
      run_case(4'd7, 32'd52_000_000, 0, 1, 1, 7'd66, 1, 0);    // R6 low range
      run_case(4'd7, 32'd52_000_000, 0, 0, 1, 7'd100, 1, 0);   // R6 field 4
      run_case(4'd10, 32'd200_000_000, 0, 0, 1, 7'd40, 1, 0);  // R4 narrow
      run_case(4'd10, 32'd200_000_000, 0, 0, 0, 7'd75, 1, 0);  // R4 wide, R7 default code
      run_case(4'd9, 32'd25_000_000, 0, 1, 1, 7'd50, 1, 0);    // R5 slow clock
      run_case(4'd4, 32'd200_000_000, 0, 1, 1, 7'd50, 1, 0);   // R3 enable off, R9
      run_case(4'd9, 32'd49_999_999, 0, 1, 1, 7'd50, 1, 0);    // R5 just below
      run_case(4'd9, 32'd50_000_000, 0, 1, 1, 7'd50, 1, 0);    // R5 at limit
      run_case(4'd8, 32'd100_000_000, 1, 1, 1, 7'd33, 1, 0);   // R3 legacy entry
      run_case(4'd3, 32'd400_000, 1, 0, 1, 7'd50, 1, 0);       // R3 legacy, chain
      run_case(4'd9, 32'd200_000_000, 0, 1, 1, 7'd50, 0, 0);   // R8 timeout
      run_case(4'd6, 32'd200_000_000, 0, 1, 1, 7'd66, 1, 1);   // R11 request while busy
      begin
         int f0;
         f0 = n_fail;
         slow_lat = 3;
         run_case(4'd2, 32'd25_000_000, 0, 1, 1, 7'd50, 1, 0);
         run_case(4'd9, 32'd200_000_000, 0, 0, 1, 7'd40, 1, 0);
         slow_lat = 0;
         chk(n_fail == f0, "R12", "failures under slow acks", n_fail, f0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL R10 watchdog expired: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule